// File: doc/BRIEF.md
# Strobed Handshake Bus Master

This block lets an on-chip client run one read or one write at a time on an external bus that uses an address strobe, a data strobe and a slave acknowledge. The client hands over a request through a valid/ready pair. The block then drives address, transfer size and direction, raises the address strobe, and raises the data strobe one clock later. After that it waits, a whole clock at a time, until the slave answers. The slave answers with a two-bit acknowledge code that also gives the width of its port.

The slave's acknowledge, bus-error and halt inputs pass through a multi-flop synchronizer before the block uses them. A nonzero acknowledge ends the cycle, and read data is captured one clock after the acknowledge is seen. Bus error with halt low aborts the cycle. Bus error with halt high makes the block drop both strobes, wait for the bus to go quiet, and rerun the same cycle. Reruns stop after a set number of attempts, and the request then reports an error. Each response is a single-clock pulse that carries the read data, the port width and an ok/error flag. The block also decodes the size code and address bit 0 into two byte-lane strobes.

Top module: `hsb_master`

## Requirements
- R1: After reset, both strobes are low, the lane strobes are 00, `req_ready` is high and `rsp_valid` is low.
- R2: A request is taken only while `req_ready` is high, and `req_ready` stays low until the response. Address, size and direction (`bus_rw`=1 for read) match the request and do not change while the address strobe is high.
- R3: The address strobe stays high for at least three clocks on every attempt, and the data strobe is high only while the address strobe is high.
- R4: On a write, `bus_wde` is high with the write data on `bus_wdata` during the clock before the data strobe rises.
- R5: Acknowledge code 00 means wait, and the block holds both strobes for as many clocks as that lasts. Code 01 means an 8-bit port, 10 a 16-bit port and 11 a 32-bit port. `rsp_port` returns the code that ended the cycle.
- R6: On a read ended by acknowledge with no error, `rsp_rdata` equals the slave's data and `rsp_err` is 0.
- R7: Bus error with halt low ends the request after one attempt with `rsp_err`=1. This also applies when the error arrives one clock after the acknowledge.
- R8: Bus error with halt high reruns the same cycle, up to MAX_TRIES attempts in total. When every attempt fails, the response has `rsp_err`=1.
- R9: `rsp_valid` and any new attempt wait until acknowledge, error and halt have all been released by the slave.
- R10: Lane strobes (bit 1 = upper byte, bit 0 = lower byte) are 00 while the data strobe is low. While it is high they are 10 for a byte (size 01) at an even address, 01 for a byte at an odd address, and 11 for any other size (10 = half, 00 = word).
- R11: `rsp_valid` is high for exactly one clock per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | Size code: 01 byte, 10 half, 00 word |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_rdata | output | DW | Read data |
| rsp_port | output | 2 | Acknowledge code that ended the cycle |
| rsp_err | output | 1 | Request ended in bus error |
| bus_addr | output | AW | Bus address |
| bus_siz | output | 2 | Bus size code |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_as | output | 1 | Address strobe (active high) |
| bus_ds | output | 1 | Data strobe (active high) |
| bus_wde | output | 1 | Write data drive enable |
| bus_wdata | output | DW | Write data to the bus |
| bus_lane | output | 2 | Byte-lane strobes {upper, lower} |
| bus_rdata | input | DW | Read data from the slave |
| bus_ack | input | 2 | Acknowledge / port-width code |
| bus_berr | input | 1 | Bus error |
| bus_halt | input | 1 | Halt (with bus error, retry) |

## Verification
The lane strobes follow the data strobe and size in the same clock. The bench samples them at the falling edge at which its slave model first sees the data strobe. The acknowledge takes two synchronizer clocks plus one decision clock before the block moves on, and a response needs the release of the slave's inputs to cross the same synchronizer. The bench therefore puts no fixed response latency on that path. It waits for the `rsp_valid` pulse, checks that the pulse comes after the recorded release clock, and checks that the pulse has dropped one clock later. The error injected one clock after the acknowledge reaches the decision logic just as the capture clock happens, which is the latest point at which it still has to count.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STRB,
        ST_WAIT,
        ST_CAPT,
        ST_TERM
    } bus_state_e;

    localparam logic [1:0] SIZ_BYTE = 2'b01;
    localparam logic [1:0] SIZ_HALF = 2'b10;
    localparam logic [1:0] SIZ_WORD = 2'b00;

    localparam logic [1:0] ACK_WAIT = 2'b00;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stage_q[g] <= '0;
                else if (g == 0) stage_q[g] <= d_i;
                else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hsb_lanes.sv
module hsb_lanes
    import hsb_pkg::*;
(
    input  logic [1:0] siz_i,
    input  logic       a0_i,
    input  logic       ds_i,
    output logic [1:0] lane_o
);
    always_comb begin
        lane_o = 2'b00;
        if (ds_i) begin
            if (siz_i == SIZ_BYTE) lane_o = a0_i ? 2'b01 : 2'b10;
            else                   lane_o = 2'b11;
        end
    end
endmodule

// File: rtl/hsb_fsm.sv
module hsb_fsm
    import hsb_pkg::*;
#(
    parameter int AW        = 24,
    parameter int DW        = 32,
    parameter int MAX_TRIES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [1:0]    rsp_port,
    output logic          rsp_err,
    input  logic [1:0]    s_ack,
    input  logic          s_berr,
    input  logic          s_halt,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_as,
    output logic          bus_ds,
    output logic          bus_rw,
    output logic          bus_wde,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_siz,
    output logic [DW-1:0] bus_wdata
);
    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam logic [TW-1:0] LAST_TRY = TW'(MAX_TRIES - 1);

    typedef struct packed {
        bus_state_e    st;
        logic [AW-1:0] addr;
        logic [1:0]    siz;
        logic          wr;
        logic [DW-1:0] wdata;
        logic [TW-1:0] tries;
        logic          retry;
        logic          err;
        logic [1:0]    port;
        logic [DW-1:0] rdata;
        logic          rsp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic err_hit, quiet;

    always_comb begin
        ctl_d   = ctl_q;
        ctl_d.rsp = 1'b0;
        err_hit = s_berr && (ctl_q.st == ST_WAIT || ctl_q.st == ST_CAPT);
        quiet   = (s_ack == ACK_WAIT) && !s_berr && !s_halt;
        case (ctl_q.st)
            ST_IDLE: if (req_valid) begin
                ctl_d.addr  = req_addr;
                ctl_d.siz   = req_size;
                ctl_d.wr    = req_write;
                ctl_d.wdata = req_wdata;
                ctl_d.tries = '0;
                ctl_d.retry = 1'b0;
                ctl_d.err   = 1'b0;
                ctl_d.st    = ST_ADDR;
            end
            ST_ADDR: ctl_d.st = ST_STRB;
            ST_STRB: ctl_d.st = ST_WAIT;
            ST_WAIT: if (!err_hit && s_ack != ACK_WAIT) begin
                ctl_d.port = s_ack;
                ctl_d.st   = ST_CAPT;
            end
            ST_CAPT: begin
                if (!ctl_q.wr) ctl_d.rdata = bus_rdata;
                if (!err_hit)  ctl_d.st    = ST_TERM;
            end
            ST_TERM: if (quiet) begin
                if (ctl_q.retry) begin
                    ctl_d.retry = 1'b0;
                    ctl_d.st    = ST_ADDR;
                end else begin
                    ctl_d.rsp = 1'b1;
                    ctl_d.st  = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (err_hit) begin
            if (s_halt && ctl_q.tries < LAST_TRY) begin
                ctl_d.retry = 1'b1;
                ctl_d.tries = ctl_q.tries + 1'b1;
            end else begin
                ctl_d.err = 1'b1;
            end
            ctl_d.st = ST_TERM;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign bus_as    = (ctl_q.st == ST_ADDR) || (ctl_q.st == ST_STRB) ||
                       (ctl_q.st == ST_WAIT) || (ctl_q.st == ST_CAPT);
    assign bus_ds    = (ctl_q.st == ST_STRB) || (ctl_q.st == ST_WAIT) ||
                       (ctl_q.st == ST_CAPT);
    assign bus_rw    = !ctl_q.wr;
    assign bus_wde   = ctl_q.wr && bus_as;
    assign bus_addr  = ctl_q.addr;
    assign bus_siz   = ctl_q.siz;
    assign bus_wdata = ctl_q.wdata;
    assign rsp_valid = ctl_q.rsp;
    assign rsp_rdata = ctl_q.rdata;
    assign rsp_port  = ctl_q.port;
    assign rsp_err   = ctl_q.err;
endmodule

// File: rtl/hsb_master.sv
module hsb_master #(
    parameter int AW          = 24,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_TRIES   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [1:0]    rsp_port,
    output logic          rsp_err,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_siz,
    output logic          bus_rw,
    output logic          bus_as,
    output logic          bus_ds,
    output logic          bus_wde,
    output logic [DW-1:0] bus_wdata,
    output logic [1:0]    bus_lane,
    input  logic [DW-1:0] bus_rdata,
    input  logic [1:0]    bus_ack,
    input  logic          bus_berr,
    input  logic          bus_halt
);
    localparam int IN_W = 4;

    logic [IN_W-1:0] raw_in, sync_in;

    assign raw_in = {bus_ack, bus_berr, bus_halt};

    hsb_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    hsb_fsm #(.AW(AW), .DW(DW), .MAX_TRIES(MAX_TRIES)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_port  (rsp_port),
        .rsp_err   (rsp_err),
        .s_ack     (sync_in[3:2]),
        .s_berr    (sync_in[1]),
        .s_halt    (sync_in[0]),
        .bus_rdata (bus_rdata),
        .bus_as    (bus_as),
        .bus_ds    (bus_ds),
        .bus_rw    (bus_rw),
        .bus_wde   (bus_wde),
        .bus_addr  (bus_addr),
        .bus_siz   (bus_siz),
        .bus_wdata (bus_wdata)
    );

    hsb_lanes i_lanes (
        .siz_i  (bus_siz),
        .a0_i   (bus_addr[0]),
        .ds_i   (bus_ds),
        .lane_o (bus_lane)
    );
endmodule

// File: rtl/hsb_master_chk.sv
module hsb_master_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_as,
    input logic          bus_ds,
    input logic          bus_rw,
    input logic          bus_wde,
    input logic [AW-1:0] bus_addr,
    input logic [1:0]    bus_siz,
    input logic [1:0]    bus_lane,
    input logic [1:0]    bus_ack,
    input logic          rsp_valid
);
    logic [7:0] as_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           as_run_q <= '0;
        else if (!bus_as)                     as_run_q <= '0;
        else if (as_run_q != 8'hFF)           as_run_q <= as_run_q + 8'd1;
    end

    // R3
    as_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_as) |-> as_run_q >= 8'd3);

    // R3
    ds_inside_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ds |-> bus_as);

    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as && $past(bus_as)) |-> ($stable(bus_addr) && $stable(bus_siz) && $stable(bus_rw)));

    // R4
    wdata_before_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_ds) && !bus_rw) |-> $past(bus_wde));

    // R10
    lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ds |-> (bus_lane == 2'b00));

    // R10
    lane_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ds && bus_siz == 2'b01) |-> ($countones(bus_lane) == 1));

    // R9
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(bus_ack) == 2'b00 && $past(bus_ack, 2) == 2'b00 && !bus_as));

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind hsb_master hsb_master_chk #(.AW(AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_as    (bus_as),
    .bus_ds    (bus_ds),
    .bus_rw    (bus_rw),
    .bus_wde   (bus_wde),
    .bus_addr  (bus_addr),
    .bus_siz   (bus_siz),
    .bus_lane  (bus_lane),
    .bus_ack   (bus_ack),
    .rsp_valid (rsp_valid)
);

// File: tb/test_hsb_master.sv
module test_hsb_master;
    localparam int AW = 24;
    localparam int DW = 32;
    localparam int MAXT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_size = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err, bus_rw, bus_as, bus_ds, bus_wde;
    logic [DW-1:0] rsp_rdata, bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic [1:0] rsp_port, bus_siz, bus_lane;
    logic [1:0] bus_ack = 2'b00;
    logic bus_berr = 1'b0, bus_halt = 1'b0;
    logic [AW-1:0] bus_addr;

    hsb_master #(.AW(AW), .DW(DW), .SYNC_STAGES(2), .MAX_TRIES(MAXT)) i_hsb_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_port(rsp_port), .rsp_err(rsp_err),
        .bus_addr(bus_addr), .bus_siz(bus_siz), .bus_rw(bus_rw), .bus_as(bus_as),
        .bus_ds(bus_ds), .bus_wde(bus_wde), .bus_wdata(bus_wdata), .bus_lane(bus_lane),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_berr(bus_berr), .bus_halt(bus_halt)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic        wr;
        logic [23:0] addr;
        logic [1:0]  siz;
        logic [1:0]  code;
        logic [3:0]  dly;
        logic [1:0]  nerr;
        logic [1:0]  mode;
        logic        exp_err;
        logic [1:0]  exp_tries;
    } vec_t;

    // mode: 0 plain acknowledge, 1 error alone, 2 error one clock after acknowledge
    localparam vec_t VECS [8] = '{
        '{1'b0, 24'h000100, 2'b00, 2'b11, 4'd0, 2'd0, 2'd0, 1'b0, 2'd1},
        '{1'b1, 24'h000201, 2'b01, 2'b01, 4'd3, 2'd0, 2'd0, 1'b0, 2'd1},
        '{1'b0, 24'h000302, 2'b10, 2'b10, 4'd5, 2'd0, 2'd0, 1'b0, 2'd1},
        '{1'b0, 24'h000403, 2'b01, 2'b11, 4'd1, 2'd0, 2'd1, 1'b1, 2'd1},
        '{1'b0, 24'h000500, 2'b10, 2'b10, 4'd2, 2'd0, 2'd2, 1'b1, 2'd1},
        '{1'b1, 24'h000604, 2'b00, 2'b11, 4'd0, 2'd2, 2'd0, 1'b0, 2'd3},
        '{1'b0, 24'h000700, 2'b00, 2'b11, 4'd0, 2'd3, 2'd0, 1'b1, 2'd3},
        '{1'b0, 24'h0007FF, 2'b01, 2'b01, 4'd8, 2'd0, 2'd0, 1'b0, 2'd1}
    };

    int checks = 0, failures = 0, cyc = 0;
    int cfg_dly = 0, cfg_mode = 0, cfg_hold = 0, err_left = 0;
    logic [1:0] cfg_code = 2'b11;
    int attempts = 0, rel_cyc = 0, rsp_cyc = 0, min_as = 99, as_len = 0;
    logic [AW-1:0] seen_addr;
    logic [1:0] seen_siz, seen_lane;
    logic seen_rw, seen_ready, seen_wde;
    logic [DW-1:0] seen_wdata;
    logic got_valid, pulse_low;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {8'h00, a} ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [1:0] exp_lane(input logic [1:0] s, input logic a0);
        if (s == 2'b01) return a0 ? 2'b01 : 2'b10;
        return 2'b11;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    initial forever begin
        @(negedge clk);
        if (bus_as) as_len++;
        else begin
            if (as_len != 0 && as_len < min_as) min_as = as_len;
            as_len = 0;
        end
    end

    // slave model
    initial forever begin
        @(negedge clk);
        if (bus_ds) begin
            attempts++;
            seen_addr = bus_addr; seen_siz = bus_siz; seen_rw = bus_rw;
            seen_lane = bus_lane; seen_ready = req_ready; seen_wde = bus_wde;
            seen_wdata = bus_wdata;
            repeat (cfg_dly) @(negedge clk);
            if (err_left > 0) begin
                bus_berr = 1'b1; bus_halt = 1'b1; err_left--;
            end else if (cfg_mode == 1) begin
                bus_berr = 1'b1;
            end else begin
                bus_ack = cfg_code; bus_rdata = pat(seen_addr);
                if (cfg_mode == 2) begin
                    @(negedge clk);
                    bus_berr = 1'b1;
                end
            end
            while (bus_as) @(negedge clk);
            repeat (cfg_hold) @(negedge clk);
            bus_ack = 2'b00; bus_berr = 1'b0; bus_halt = 1'b0;
            rel_cyc = cyc;
        end
    end

    task automatic do_req(input logic wr, input logic [AW-1:0] a, input logic [1:0] s, input logic [DW-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = s; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        got_valid = 1'b0;
        for (int k = 0; k < 2000 && !got_valid; k++) begin
            @(negedge clk);
            if (rsp_valid) begin got_valid = 1'b1; rsp_cyc = cyc; end
        end
        @(negedge clk);
        pulse_low = !rsp_valid;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!bus_as && !bus_ds, "R1 strobes", {30'd0, bus_as, bus_ds}, 0);
        chk(req_ready && !rsp_valid, "R1 ready/rsp", {30'd0, req_ready, rsp_valid}, 2);
        chk(bus_lane == 2'b00, "R10 lanes idle", bus_lane, 0);

        for (int i = 0; i < 8; i++) begin
            vec_t v;
            logic [DW-1:0] wd;
            v = VECS[i];
            wd = 32'hC0DE0000 | i;
            cfg_dly = v.dly; cfg_mode = v.mode; cfg_code = v.code; err_left = v.nerr; cfg_hold = 0;
            attempts = 0;
            do_req(v.wr, v.addr, v.siz, wd);
            chk(got_valid, "R5 response arrives", got_valid, 1);
            chk(pulse_low, "R11 single pulse", pulse_low, 1);
            chk(seen_addr == v.addr && seen_siz == v.siz && seen_rw == !v.wr, "R2 bus fields",
                {seen_rw, seen_siz, seen_addr}, {!v.wr, v.siz, v.addr});
            chk(!seen_ready, "R2 busy not ready", seen_ready, 0);
            chk(seen_lane == exp_lane(v.siz, v.addr[0]), "R10 lanes", seen_lane, exp_lane(v.siz, v.addr[0]));
            if (v.wr) chk(seen_wde && seen_wdata == wd, "R4 write data", seen_wdata, wd);
            chk(rsp_err == v.exp_err, v.mode != 0 ? "R7 error" : "R8 retry result", rsp_err, v.exp_err);
            chk(attempts == v.exp_tries, v.nerr != 0 ? "R8 attempt count" : "R7 attempt count", attempts, v.exp_tries);
            if (!v.exp_err) chk(rsp_port == v.code, "R5 port code", rsp_port, v.code);
            if (!v.exp_err && !v.wr) chk(rsp_rdata == pat(v.addr), "R6 read data", rsp_rdata, pat(v.addr));
        end

        // R9: slave holds acknowledge after address strobe drops
        cfg_dly = 1; cfg_mode = 0; cfg_code = 2'b10; err_left = 0; cfg_hold = 6; attempts = 0;
        do_req(1'b0, 24'h000ABC, 2'b00, '0);
        chk(got_valid && rsp_cyc > rel_cyc, "R9 waits for release", rsp_cyc, rel_cyc + 1);
        chk(rsp_rdata == pat(24'h000ABC) && !rsp_err, "R6 read after hold", rsp_rdata, pat(24'h000ABC));
        cfg_hold = 0;

        // R3: address strobe length across all attempts
        chk(min_as >= 3, "R3 strobe length", min_as, 3);
        // R1/R10 back at idle
        chk(req_ready && bus_lane == 2'b00 && !bus_as, "R1 idle after run", {bus_lane, req_ready}, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule